// File: doc/BRIEF.md
# Cross-Bus Eight-Channel DMA Engine

This block moves bytes between two buses without processor involvement. One bus (the wide bus) carries a 24-bit address. The other (the narrow bus) carries only an 8-bit register address. Every byte is read from one bus and written to the other in the same cycle. Eight channels are programmed through a small register port. Any number of channels may be armed at once, and pending work is served one byte per cycle.

Each channel runs in one of two modes. In block mode, a start command queues a complete transfer of the programmed byte count, and the processor stall output stays high until the last byte has moved. In line mode, a channel is armed by the start command and then moves a short burst of one to four bytes after each horizontal-blank pulse. A vertical-blank pulse rewinds every armed line channel to its start address and its full line budget. A horizontal blank that arrives during a block transfer suspends that transfer until the line bursts have finished, and the block transfer then continues from where it stopped.

Top module: `xbus_dma`

## Requirements
- R1: Out of reset, `cpu_stall`, `cfg_reject` and all four bus strobes are low.
- R2: Block mode moves exactly the programmed number of bytes, one per cycle. The first byte appears in the cycle after the start write. The wide-bus address starts at the programmed base and steps by one per byte. The narrow-bus address stays at its base. The source bus is selected by control bit 0 (1 = narrow bus) and the destination bus by control bit 1 (1 = narrow bus). The data written equals the data read in the same cycle.
- R3: A programmed count of 0 means 65536 bytes.
- R4: A start command to a channel whose control bits 0 and 1 are equal is refused. `cfg_reject` is high for one cycle, in the cycle after the start write, and no bytes move and no stall is raised for that channel.
- R5: `cpu_stall` is high in exactly those cycles from the first byte of a block transfer through its last byte, counting any suspension. It falls in the cycle after the last byte.
- R6: When several channels are waiting, the lowest-numbered channel is served first and finishes before any higher-numbered channel of the same mode starts.
- R7: A line-mode channel (control bit 3 = 1) moves nothing when armed. After each horizontal-blank pulse it moves its burst without stalling the processor. Burst byte k goes to narrow-bus address base+k, and the wide-bus address continues from where the previous burst stopped.
- R8: The burst length is control field bits [5:4] plus one, so a burst moves at most 4 bytes.
- R9: A line channel serves as many horizontal blanks as its count field, and later pulses move nothing. A vertical-blank pulse reloads its start address and line count. No byte moves in a cycle in which `vblank` is high.
- R10: A horizontal blank during a block transfer suspends it while the line bursts run. The block transfer then resumes at the next address, with no byte lost or repeated, and `cpu_stall` stays high throughout.
- R11: With control bit 2 = 1, the wide-bus address stays at its base for every byte.
- R12: In each cycle, at most one byte moves. A cycle that moves a byte reads exactly one bus and writes the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Programming write strobe |
| cfg_ch | input | 3 | Channel selected for field writes |
| cfg_field | input | 3 | Field code: 0 control, 1 wide base, 2 narrow base, 3 count, 4 start mask |
| cfg_wdata | input | 24 | Write data; for field 4, bit i starts channel i |
| hblank | input | 1 | One-cycle horizontal-blank pulse |
| vblank | input | 1 | One-cycle vertical-blank pulse |
| a_addr | output | 24 | Wide-bus address |
| a_rd | output | 1 | Wide-bus read strobe |
| a_wr | output | 1 | Wide-bus write strobe |
| a_wdata | output | 8 | Wide-bus write data |
| a_rdata | input | 8 | Wide-bus read data, valid in the same cycle |
| b_addr | output | 8 | Narrow-bus address |
| b_rd | output | 1 | Narrow-bus read strobe |
| b_wr | output | 1 | Narrow-bus write strobe |
| b_wdata | output | 8 | Narrow-bus write data |
| b_rdata | input | 8 | Narrow-bus read data, valid in the same cycle |
| cpu_stall | output | 1 | Processor hold while block work is pending |
| cfg_reject | output | 1 | One-cycle pulse for a refused start |

## Verification
The properties assume the following about the inputs. Blanking pulses last one cycle. Horizontal pulses are spaced far enough apart that every burst finishes before the next pulse; the burst-run bound depends on this. A channel is never reprogrammed or restarted while it is moving data. The bench keeps to these limits in three ways: its random block transfers only target idle channels and never pulse blanking, every directed line test waits at least twelve cycles between pulses, and the suspension test raises a single horizontal pulse in the middle of one block transfer.

// File: rtl/xbus_dma_pkg.sv
`timescale 1ns/1ps
package xbus_dma_pkg;
   // programming field codes
   typedef enum logic [2:0] {
      FLD_CTRL  = 3'd0,
      FLD_ABASE = 3'd1,
      FLD_BBASE = 3'd2,
      FLD_COUNT = 3'd3,
      FLD_START = 3'd4
   } fld_e;

   // control word bit positions
   localparam int unsigned CB_SRC_B = 0;
   localparam int unsigned CB_DST_B = 1;
   localparam int unsigned CB_FIXED = 2;
   localparam int unsigned CB_LINE  = 3;
   localparam int unsigned CB_BLEN  = 4;
endpackage

// File: rtl/xbus_dma_prio.sv
`timescale 1ns/1ps
module xbus_dma_prio #(
   parameter int unsigned N = 8
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt,
   output logic         any
);
   always_comb begin
      logic found;
      found = 1'b0;
      gnt   = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !found) begin
            gnt[i] = 1'b1;
            found  = 1'b1;
         end
      end
   end

   assign any = |req;
endmodule

// File: rtl/xbus_dma_chan.sv
`timescale 1ns/1ps
module xbus_dma_chan
   import xbus_dma_pkg::*;
#(
   parameter int unsigned AW  = 24,
   parameter int unsigned BW  = 8,
   parameter int unsigned CW  = 16,
   parameter int unsigned BLW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  fld_e          wr_field,
   input  logic [AW-1:0] wr_data,
   input  logic          start,
   input  logic          hblank,
   input  logic          vblank,
   input  logic          grant,
   input  logic          serve_line,
   output logic          gen_pend,
   output logic          line_req,
   output logic [AW-1:0] a_addr,
   output logic [BW-1:0] b_addr,
   output logic          src_b,
   output logic          bad_cfg
);
   localparam int unsigned RW = CW + 1;

   logic           src_b_q, dst_b_q, fixed_q, line_q;
   logic [BLW-1:0] blen_q;
   logic [AW-1:0]  abase_q;
   logic [BW-1:0]  bbase_q;
   logic [CW-1:0]  count_q;

   logic [AW-1:0]  acur_q;
   logic [RW-1:0]  rem_q;
   logic           gen_q, arm_q, req_q;
   logic [BLW-1:0] bidx_q;
   logic [RW-1:0]  full_cnt;

   assign full_cnt = (count_q == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, count_q};
   assign bad_cfg  = (src_b_q == dst_b_q);

   // programmed descriptor
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_b_q <= 1'b0;
         dst_b_q <= 1'b0;
         fixed_q <= 1'b0;
         line_q  <= 1'b0;
         blen_q  <= '0;
         abase_q <= '0;
         bbase_q <= '0;
         count_q <= '0;
      end else if (wr_en) begin
         case (wr_field)
            FLD_CTRL: begin
               src_b_q <= wr_data[CB_SRC_B];
               dst_b_q <= wr_data[CB_DST_B];
               fixed_q <= wr_data[CB_FIXED];
               line_q  <= wr_data[CB_LINE];
               blen_q  <= wr_data[CB_BLEN +: BLW];
            end
            FLD_ABASE: abase_q <= wr_data;
            FLD_BBASE: bbase_q <= wr_data[BW-1:0];
            FLD_COUNT: count_q <= wr_data[CW-1:0];
            default: ;
         endcase
      end
   end

   // working state
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acur_q <= '0;
         rem_q  <= '0;
         gen_q  <= 1'b0;
         arm_q  <= 1'b0;
         req_q  <= 1'b0;
         bidx_q <= '0;
      end else if (start && !bad_cfg) begin
         acur_q <= abase_q;
         rem_q  <= full_cnt;
         bidx_q <= '0;
         req_q  <= 1'b0;
         gen_q  <= !line_q;
         arm_q  <= line_q;
      end else if (vblank && arm_q) begin
         acur_q <= abase_q;
         rem_q  <= full_cnt;
         req_q  <= 1'b0;
         bidx_q <= '0;
      end else if (hblank && arm_q && rem_q != '0) begin
         req_q  <= 1'b1;
         bidx_q <= '0;
      end else if (grant) begin
         if (!fixed_q) acur_q <= acur_q + AW'(1);
         if (serve_line) begin
            if (bidx_q == blen_q) begin
               req_q  <= 1'b0;
               bidx_q <= '0;
               rem_q  <= rem_q - RW'(1);
            end else begin
               bidx_q <= bidx_q + BLW'(1);
            end
         end else begin
            rem_q <= rem_q - RW'(1);
            if (rem_q == RW'(1)) gen_q <= 1'b0;
         end
      end
   end

   assign gen_pend = gen_q;
   assign line_req = req_q;
   assign a_addr   = acur_q;
   assign b_addr   = bbase_q + BW'(bidx_q);
   assign src_b    = src_b_q;
endmodule

// File: rtl/xbus_dma_mover.sv
`timescale 1ns/1ps
module xbus_dma_mover #(
   parameter int unsigned N  = 8,
   parameter int unsigned AW = 24,
   parameter int unsigned BW = 8
) (
   input  logic [N-1:0]    gnt,
   input  logic [N*AW-1:0] a_flat,
   input  logic [N*BW-1:0] b_flat,
   input  logic [N-1:0]    srcb_vec,
   input  logic [7:0]      a_rdata,
   input  logic [7:0]      b_rdata,
   output logic [AW-1:0]   a_addr,
   output logic            a_rd,
   output logic            a_wr,
   output logic [7:0]      a_wdata,
   output logic [BW-1:0]   b_addr,
   output logic            b_rd,
   output logic            b_wr,
   output logic [7:0]      b_wdata
);
   logic          act, s_sel;
   logic [AW-1:0] a_sel;
   logic [BW-1:0] b_sel;

   always_comb begin
      a_sel = '0;
      b_sel = '0;
      s_sel = 1'b0;
      for (int i = 0; i < N; i++) begin
         a_sel = a_sel | ({AW{gnt[i]}} & a_flat[i*AW +: AW]);
         b_sel = b_sel | ({BW{gnt[i]}} & b_flat[i*BW +: BW]);
         s_sel = s_sel | (gnt[i] & srcb_vec[i]);
      end
   end

   assign act     = |gnt;
   assign a_addr  = a_sel;
   assign b_addr  = b_sel;
   assign a_rd    = act & ~s_sel;
   assign b_wr    = act & ~s_sel;
   assign b_rd    = act &  s_sel;
   assign a_wr    = act &  s_sel;
   assign a_wdata = b_rdata;
   assign b_wdata = a_rdata;
endmodule

// File: rtl/xbus_dma.sv
`timescale 1ns/1ps
module xbus_dma
   import xbus_dma_pkg::*;
#(
   parameter int unsigned NCH       = 8,
   parameter int unsigned AW        = 24,
   parameter int unsigned BW        = 8,
   parameter int unsigned CW        = 16,
   parameter int unsigned MAX_BURST = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [$clog2(NCH)-1:0] cfg_ch,
   input  logic [2:0]             cfg_field,
   input  logic [AW-1:0]          cfg_wdata,
   input  logic                   hblank,
   input  logic                   vblank,
   output logic [AW-1:0]          a_addr,
   output logic                   a_rd,
   output logic                   a_wr,
   output logic [7:0]             a_wdata,
   input  logic [7:0]             a_rdata,
   output logic [BW-1:0]          b_addr,
   output logic                   b_rd,
   output logic                   b_wr,
   output logic [7:0]             b_wdata,
   input  logic [7:0]             b_rdata,
   output logic                   cpu_stall,
   output logic                   cfg_reject
);
   localparam int unsigned CHW = $clog2(NCH);
   localparam int unsigned BLW = $clog2(MAX_BURST);

   if (NCH < 2 || NCH > AW) begin : g_chk_nch
      $error("xbus_dma: NCH must lie between 2 and AW");
   end
   if (MAX_BURST < 2 || (1 << BLW) != MAX_BURST) begin : g_chk_burst
      $error("xbus_dma: MAX_BURST must be a power of two of at least 2");
   end
   if (AW < CW || AW < BW || AW < CB_BLEN + BLW) begin : g_chk_aw
      $error("xbus_dma: AW too narrow for the programming fields");
   end

   fld_e            fld;
   logic [NCH-1:0]  wr_en, start_vec, gen_vec, lreq_vec, srcb_vec, bad_vec;
   logic [NCH-1:0]  line_gnt, gen_gnt, gnt_eff;
   logic            line_any, gen_any, move_en;
   logic [NCH*AW-1:0] a_flat;
   logic [NCH*BW-1:0] b_flat;
   logic            reject_q;

   assign fld = fld_e'(cfg_field);

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign wr_en[i]     = cfg_we && (fld != FLD_START) && (cfg_ch == CHW'(i));
      assign start_vec[i] = cfg_we && (fld == FLD_START) && cfg_wdata[i];

      xbus_dma_chan #(.AW(AW), .BW(BW), .CW(CW), .BLW(BLW)) u_ch (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_en      (wr_en[i]),
         .wr_field   (fld),
         .wr_data    (cfg_wdata),
         .start      (start_vec[i]),
         .hblank     (hblank),
         .vblank     (vblank),
         .grant      (gnt_eff[i]),
         .serve_line (line_any),
         .gen_pend   (gen_vec[i]),
         .line_req   (lreq_vec[i]),
         .a_addr     (a_flat[i*AW +: AW]),
         .b_addr     (b_flat[i*BW +: BW]),
         .src_b      (srcb_vec[i]),
         .bad_cfg    (bad_vec[i])
      );
   end

   xbus_dma_prio #(.N(NCH)) u_line_prio (.req(lreq_vec), .gnt(line_gnt), .any(line_any));
   xbus_dma_prio #(.N(NCH)) u_gen_prio  (.req(gen_vec),  .gnt(gen_gnt),  .any(gen_any));

   // line bursts preempt block work; nothing moves while vblank reloads
   assign move_en = ~vblank;
   assign gnt_eff = move_en ? (line_any ? line_gnt : gen_gnt) : '0;

   xbus_dma_mover #(.N(NCH), .AW(AW), .BW(BW)) u_mover (
      .gnt      (gnt_eff),
      .a_flat   (a_flat),
      .b_flat   (b_flat),
      .srcb_vec (srcb_vec),
      .a_rdata  (a_rdata),
      .b_rdata  (b_rdata),
      .a_addr   (a_addr),
      .a_rd     (a_rd),
      .a_wr     (a_wr),
      .a_wdata  (a_wdata),
      .b_addr   (b_addr),
      .b_rd     (b_rd),
      .b_wr     (b_wr),
      .b_wdata  (b_wdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) reject_q <= 1'b0;
      else        reject_q <= |(start_vec & bad_vec);
   end

   assign cfg_reject = reject_q;
   assign cpu_stall  = gen_any;
endmodule

// File: rtl/xbus_dma_chk.sv
`timescale 1ns/1ps
module xbus_dma_chk #(
   parameter int unsigned NCH  = 8,
   parameter int unsigned MAXB = 4
) (
   input logic clk,
   input logic rst_n,
   input logic a_rd,
   input logic a_wr,
   input logic b_rd,
   input logic b_wr,
   input logic cpu_stall,
   input logic vblank
);
   localparam int unsigned RUN_MAX = NCH * MAXB;

   logic        moving;
   logic [15:0] run_q;

   assign moving = a_rd || a_wr;

   always_ff @(posedge clk) begin
      if (!rst_n)                  run_q <= '0;
      else if (moving && !cpu_stall) run_q <= run_q + 16'd1;
      else                         run_q <= '0;
   end

   a_r12_a_one_way: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_rd && a_wr));
   a_r12_b_one_way: assert property (@(posedge clk) disable iff (!rst_n)
      !(b_rd && b_wr));
   a_r12_paired: assert property (@(posedge clk) disable iff (!rst_n)
      (a_rd || a_wr) == (b_rd || b_wr));
   a_r2_crosses: assert property (@(posedge clk) disable iff (!rst_n)
      a_rd |-> b_wr);
   a_r5_stall_release: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_stall) |-> $past(moving));
   a_r9_vblank_idle: assert property (@(posedge clk) disable iff (!rst_n)
      vblank |-> !moving);
   a_r8_burst_bound: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= 16'(RUN_MAX));
endmodule

bind xbus_dma xbus_dma_chk #(.NCH(NCH), .MAXB(MAX_BURST)) u_chk (.*);

// File: tb/tb_xbus_dma.sv
`timescale 1ns/1ps
module tb_xbus_dma;
   import xbus_dma_pkg::*;
   localparam int unsigned NCH = 8, AW = 24, BW = 8, CW = 16, MAXB = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_ch = '0;
   logic [2:0]    cfg_field = '0;
   logic [AW-1:0] cfg_wdata = '0;
   logic          hblank = 1'b0, vblank = 1'b0;
   logic [AW-1:0] a_addr;
   logic          a_rd, a_wr, b_rd, b_wr, cpu_stall, cfg_reject;
   logic [7:0]    a_wdata, a_rdata, b_wdata, b_rdata;
   logic [BW-1:0] b_addr;

   xbus_dma #(.NCH(NCH), .AW(AW), .BW(BW), .CW(CW), .MAX_BURST(MAXB)) dut (.*);

   logic [7:0] amem [0:4095];
   logic [7:0] bmem [0:255];
   assign a_rdata = amem[a_addr[11:0]];
   assign b_rdata = bmem[b_addr];
   always @(posedge clk) begin
      if (a_wr) amem[a_addr[11:0]] <= a_wdata;
      if (b_wr) bmem[b_addr] <= b_wdata;
   end

   int total = 0, bad = 0, n_log = 0, n_stall = 0;
   bit done = 1'b0;
   logic [AW-1:0] lg_a [0:63];
   logic [7:0]    lg_b [0:63];
   logic          lg_s [0:63];
   logic [7:0]    lg_d [0:63];

   always @(negedge clk) begin
      if (rst_n) begin
         if (cpu_stall) n_stall++;
         if (a_rd || a_wr) begin
            if (n_log < 64) begin
               lg_a[n_log] = a_addr;
               lg_b[n_log] = b_addr;
               lg_s[n_log] = b_rd;
               lg_d[n_log] = a_rd ? a_rdata : b_rdata;
            end
            n_log++;
         end
      end
   end

   function automatic logic [7:0] pat(input int i);
      return 8'(i * 13 + 5);
   endfunction

   function automatic logic [AW-1:0] ctl(input bit sb, input bit db, input bit fx,
                                         input bit ln, input int blm1);
      return AW'({blm1[1:0], ln, fx, db, sb});
   endfunction

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp,
                        input string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic wr(input int ch, input fld_e f, input logic [AW-1:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_field = f; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic setup(input int ch, input logic [AW-1:0] c, input logic [AW-1:0] a,
                        input logic [AW-1:0] b, input logic [AW-1:0] n);
      wr(ch, FLD_CTRL, c);
      wr(ch, FLD_ABASE, a);
      wr(ch, FLD_BBASE, b);
      wr(ch, FLD_COUNT, n);
   endtask

   task automatic start(input logic [AW-1:0] mask);
      wr(0, FLD_START, mask);
   endtask

   task automatic clr();
      @(negedge clk);
      n_log = 0; n_stall = 0;
   endtask

   task automatic wait_idle(input int lim);
      int k = 0;
      while (cpu_stall && k < lim) begin
         @(negedge clk);
         k++;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic hpulse();
      @(negedge clk); hblank = 1'b1;
      @(negedge clk); hblank = 1'b0;
      repeat (12) @(negedge clk);
   endtask

   task automatic vpulse();
      @(negedge clk); vblank = 1'b1;
      @(negedge clk); vblank = 1'b0;
      @(negedge clk);
   endtask

   task automatic ent(input string rq, input int i, input logic [AW-1:0] ea,
                      input logic [7:0] eb, input logic es);
      check(rq, 32'(lg_a[i]), 32'(ea), "wide address");
      check(rq, 32'(lg_b[i]), 32'(eb), "narrow address");
      check(rq, 32'(lg_s[i]), 32'(es), "source bus");
   endtask

   // one line frame: ch4 bursts of 4, ch7 bursts of 2
   task automatic line_set(input string rq, input int off4, input int off7);
      check(rq, 32'(n_log), 32'd6, "bytes per line");
      for (int k = 0; k < 4; k++) ent(rq, k, AW'('h600 + off4 + k), 8'('h20 + k), 1'b0);
      for (int k = 0; k < 2; k++) ent(rq, 4 + k, AW'('h700 + off7 + k), 8'('h30 + k), 1'b0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL R5 watchdog: actual=%0d expected<%0d cycles", 190000, 190000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4096; i++) amem[i] = pat(i);
      for (int i = 0; i < 256; i++)  bmem[i] = 8'(i ^ 8'hC3);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", 32'(cpu_stall), 0, "stall");
      check("R1", 32'(cfg_reject), 0, "reject");
      check("R1", 32'({a_rd, a_wr, b_rd, b_wr}), 0, "strobes");

      // R2 R5 wide to narrow block transfer
      setup(2, ctl(0, 1, 0, 0, 0), 'h100, 'h18, 5);
      clr();
      start(1 << 2);
      wait_idle(100);
      check("R2", 32'(n_log), 5, "byte count");
      check("R5", 32'(n_stall), 5, "stall cycles");
      for (int k = 0; k < 5; k++) begin
         ent("R2", k, AW'('h100 + k), 8'h18, 1'b0);
         check("R2", 32'(lg_d[k]), 32'(amem['h100 + k]), "moved data");
      end
      check("R2", 32'(bmem['h18]), 32'(amem['h104]), "final narrow byte");

      // R2 narrow to wide
      bmem['h40] = 8'h5A;
      setup(5, ctl(1, 0, 0, 0, 0), 'h200, 'h40, 3);
      clr();
      start(1 << 5);
      wait_idle(100);
      check("R2", 32'(n_log), 3, "byte count narrow source");
      for (int k = 0; k < 3; k++) begin
         ent("R2", k, AW'('h200 + k), 8'h40, 1'b1);
         check("R2", 32'(amem['h200 + k]), 32'h5A, "wide copy");
      end

      // R11 fixed wide address
      setup(1, ctl(0, 1, 1, 0, 0), 'h300, 'h19, 4);
      clr();
      start(1 << 1);
      wait_idle(100);
      check("R11", 32'(n_log), 4, "byte count");
      for (int k = 0; k < 4; k++) ent("R11", k, AW'('h300), 8'h19, 1'b0);

      // R4 same-bus refusals
      for (int v = 0; v < 2; v++) begin
         setup(3, ctl(v[0], v[0], 0, 0, 0), 'h380, 'h1A, 2);
         clr();
         start(1 << 3);
         check("R4", 32'(cfg_reject), 1, "reject pulse");
         check("R4", 32'(cpu_stall), 0, "no stall");
         repeat (8) @(negedge clk);
         check("R4", 32'(cfg_reject), 0, "reject drops");
         check("R4", 32'(n_log), 0, "no bytes moved");
      end

      // R6 lower channel first
      setup(6, ctl(0, 1, 0, 0, 0), 'h500, 'h60, 3);
      setup(1, ctl(0, 1, 0, 0, 0), 'h400, 'h61, 3);
      clr();
      start((1 << 6) | (1 << 1));
      wait_idle(100);
      check("R6", 32'(n_log), 6, "byte count");
      check("R5", 32'(n_stall), 6, "stall cycles for two channels");
      for (int k = 0; k < 3; k++) ent("R6", k, AW'('h400 + k), 8'h61, 1'b0);
      for (int k = 0; k < 3; k++) ent("R6", 3 + k, AW'('h500 + k), 8'h60, 1'b0);

      // R3 count zero means 65536
      setup(0, ctl(0, 1, 0, 0, 0), 'h000, 'h70, 0);
      clr();
      start(1 << 0);
      wait_idle(70000);
      check("R3", 32'(n_log), 65536, "byte count");
      check("R3", 32'(n_stall), 65536, "stall cycles");

      // R7 R8 R9 line mode
      setup(4, ctl(0, 1, 0, 1, 3), 'h600, 'h20, 2);
      setup(7, ctl(0, 1, 0, 1, 1), 'h700, 'h30, 3);
      clr();
      start(8'h90);
      repeat (3) @(negedge clk);
      check("R7", 32'(n_log), 0, "armed channel idle");
      check("R7", 32'(cpu_stall), 0, "arming does not stall");
      hpulse();
      line_set("R8", 0, 0);
      check("R7", 32'(n_stall), 0, "line burst without stall");
      clr(); hpulse();
      line_set("R7", 4, 2);
      clr(); hpulse();
      check("R9", 32'(n_log), 2, "only one channel left");
      for (int k = 0; k < 2; k++) ent("R9", k, AW'('h704 + k), 8'('h30 + k), 1'b0);
      clr(); hpulse();
      check("R9", 32'(n_log), 0, "line budget used");
      clr(); vpulse();
      check("R9", 32'(n_log), 0, "vblank moves nothing");
      hpulse();
      line_set("R9", 0, 0);

      // R10 suspension of a block transfer
      vpulse();
      setup(2, ctl(0, 1, 0, 0, 0), 'h800, 'h50, 20);
      clr();
      start(1 << 2);
      repeat (4) @(negedge clk);
      @(negedge clk); hblank = 1'b1;
      @(negedge clk); hblank = 1'b0;
      wait_idle(200);
      check("R10", 32'(n_log), 26, "total bytes");
      check("R10", 32'(n_stall), 26, "stall held through pause");
      begin
         int gi = 0, first = -1;
         for (int i = 0; i < n_log && i < 64; i++) begin
            if (lg_b[i] == 8'h50) begin
               check("R10", 32'(lg_a[i]), 32'('h800 + gi), "resumed address");
               gi++;
            end else if (first < 0) begin
               first = i;
            end
         end
         check("R10", 32'(gi), 20, "block bytes");
         check("R10", 32'(first > 0 && first + 6 < n_log), 1, "bursts inside block");
         if (first > 0) begin
            for (int k = 0; k < 4; k++) ent("R10", first + k, AW'('h600 + k), 8'('h20 + k), 1'b0);
            for (int k = 0; k < 2; k++) ent("R10", first + 4 + k, AW'('h700 + k), 8'('h30 + k), 1'b0);
         end
      end

      // random block transfers
      void'($urandom(32'd1234));
      for (int it = 0; it < 10; it++) begin
         int chs[6] = '{0, 1, 2, 3, 5, 6};
         int ch = chs[$urandom_range(5)];
         bit sb = 1'($urandom_range(1));
         bit fx = 1'($urandom_range(1));
         int n  = int'($urandom_range(16, 1));
         logic [AW-1:0] a = AW'('hA00 + $urandom_range(255));
         logic [7:0] b = 8'($urandom_range(255));
         if (sb) bmem[b] = 8'($urandom_range(255));
         setup(ch, ctl(sb, !sb, fx, 0, 0), a, AW'(b), AW'(n));
         clr();
         start(AW'(1) << ch);
         wait_idle(100);
         check("R2", 32'(n_log), 32'(n), "random byte count");
         check("R5", 32'(n_stall), 32'(n), "random stall cycles");
         for (int k = 0; k < n; k++) begin
            logic [AW-1:0] ea = fx ? a : a + AW'(k);
            ent(fx ? "R11" : "R2", k, ea, b, sb);
            if (sb) check("R2", 32'(amem[ea[11:0]]), 32'(bmem[b]), "random wide write");
            else    check("R2", 32'(lg_d[k]), 32'(amem[ea[11:0]]), "random read data");
         end
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule